// File: doc/BRIEF.md
# Two-Wire Serial Control Register Slave

This block is a two-wire serial bus slave that owns three 8-bit control registers and presents them to the rest of the chip as parallel outputs. The bus master writes them by sending the slave address, one subaddress byte and one or more data bytes. When several data bytes follow, the target register advances through a fixed order on each byte.

Reads carry no subaddress. A read returns an identification constant if the last write transfer chose the identification subaddress. Otherwise it returns a status byte. The top bit of the status byte is a power-on flag, which the first completed status read clears.

SCL and SDA arrive as raw pin samples and are synchronised and edge-detected inside the block, which runs on a system clock much faster than the bus. The block drives the bus through a single SDA pull-down enable, for an open-drain pad. It never stretches the clock. It does not support general call or 10-bit addressing. All pins are plain control and status signals, because the block has no streaming interface.

Top module: `ctl_i2c_regfile`

## Requirements
- R1: The slave answers the 7-bit address 1011011 when `adr_sel_i` is 1 and 1011010 when it is 0. A transfer to any other address gets no ACK: SDA stays released and no register changes.
- R2: A write transfer sends the address with R/W = 0, then a subaddress byte, then data bytes. The slave ACKs the address and every following byte by pulling SDA low in the ninth clock.
- R3: Subaddress 0 selects the switching register (`sw_reg_o`), 1 selects the adjust register (`adj_reg_o`) and 2 selects the port register (`port_reg_o`). Each further data byte in the same transfer goes to the next register in the order 0, 1, 2, 0, and so on.
- R4: A register takes a new value only after all eight bits and the ACK clock of its data byte are complete. A byte cut short by START or STOP leaves the register unchanged.
- R5: After reset the registers hold switching = 0xC0, adjust = 0x06 and port = 0x3B, and SDA is released.
- R6: Bits 7:6 of the port register always read 0, whatever value is written.
- R7: After a write transfer whose subaddress is 254, every read returns 0x80. This holds until a later write transfer uses a different subaddress.
- R8: Any other read returns the status byte, with the power-on flag in bit 7 and `stat_i[6:0]` in bits 6:0. The block samples the status byte at the start of each byte it sends.
- R9: The power-on flag is 1 after reset. It becomes 0 once the ACK or NACK clock of a transmitted status byte completes, and it stays 0 until the next reset.
- R10: In a read, a master ACK makes the slave send the byte again, sampled afresh. After a master NACK the slave leaves SDA released.
- R11: Data bytes written to a subaddress other than 0, 1 and 2 are ACKed but change no register.
- R12: START and STOP are recognised in any state. A repeated START inside a transfer restarts address decoding, so a second transfer can follow without a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset, also the power-on event |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level (wired-AND of the bus) |
| adr_sel_i | input | 1 | Address select: 1 when left open, 0 when tied low |
| stat_i | input | 7 | Status bits returned in bits 6:0 of the status byte |
| sda_pd_o | output | 1 | SDA pull-down enable for an open-drain pad |
| sw_reg_o | output | 8 | Switching register |
| adj_reg_o | output | 8 | Adjust/standard register |
| port_reg_o | output | 8 | Port register, bits 7:6 always 0 |

## Verification
The write path gets random transfers of one to four bytes starting at random subaddresses. Because the results depend on the wrap order, a wrong increment step or a missed wrap shows up. Directed cases target the edges of the protocol: a wrong address, both states of the select pin, a byte cut off by STOP, an out-of-range subaddress and a repeated START in the middle of a write. Together they separate "ACK but ignore" from "commit" and show when a commit takes place. The read side checks, byte by byte, both the identification path and the status path under master ACK and NACK. This catches a power-on flag that clears too early or too late, and an identification selection that does not persist or does not end.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;

  localparam int NREG      = 3;
  localparam int DW        = 8;
  localparam int IDXW      = $clog2(NREG);
  localparam logic [5:0] DEV_ADDR_HI = 6'b101101;
  localparam logic [7:0] ID_SUBADDR  = 8'hFE;
  localparam logic [7:0] ID_CODE     = 8'h80;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_SUB, ST_ACK_S,
    ST_DATA, ST_ACK_D, ST_TX, ST_RACK
  } eng_state_e;

  function automatic logic [DW-1:0] reg_default(input int idx);
    case (idx)
      0:       return 8'hC0;
      1:       return 8'h06;
      default: return 8'h3B;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_mask(input int idx);
    return (idx == 2) ? 8'h3F : 8'hFF;
  endfunction

endpackage

// File: rtl/ctl_i2c_sync.sv
module ctl_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] line_in;
  logic [1:0] line_s;
  logic [1:0] line_p;

  assign line_in = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain     <= '1;
          line_p[g] <= 1'b1;
        end else begin
          chain     <= {chain[STAGES-2:0], line_in[g]};
          line_p[g] <= chain[STAGES-1];
        end
      end
      assign line_s[g] = chain[STAGES-1];
    end
  endgenerate

  assign scl_s    = line_s[0];
  assign sda_s    = line_s[1];
  assign scl_rise = line_s[0] & ~line_p[0];
  assign scl_fall = ~line_s[0] & line_p[0];
  assign start_ev = line_s[0] & line_p[0] & line_p[1] & ~line_s[1];
  assign stop_ev  = line_s[0] & line_p[0] & ~line_p[1] & line_s[1];
endmodule

// File: rtl/ctl_i2c_engine.sv
module ctl_i2c_engine
  import ctl_i2c_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_ev,
  input  logic            stop_ev,
  input  logic            adr_sel,
  input  logic [DW-1:0]   status_byte,
  output logic            sda_pd,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [DW-1:0]   wr_data,
  output logic            por_clr,
  output logic            active
);
  eng_state_e    st;
  logic [DW-1:0] sh;
  logic [3:0]    cnt;
  logic          rw_q;
  logic          tx_stat;
  logic          mack;
  logic          id_sel;
  logic [DW-1:0] ptr;
  logic [6:0]    my_addr;
  logic [DW-1:0] tx_byte;

  assign my_addr = {DEV_ADDR_HI, adr_sel};
  assign tx_byte = id_sel ? ID_CODE : status_byte;
  assign active  = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sh      <= '0;
      cnt     <= '0;
      rw_q    <= 1'b0;
      tx_stat <= 1'b0;
      mack    <= 1'b0;
      id_sel  <= 1'b0;
      ptr     <= '0;
      sda_pd  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      por_clr <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      por_clr <= 1'b0;
      if (start_ev) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_pd <= 1'b0;
      end else if (stop_ev) begin
        st     <= ST_IDLE;
        sda_pd <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_SUB, ST_DATA: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == my_addr) begin
                  sda_pd <= 1'b1;
                  rw_q   <= sh[0];
                  st     <= ST_ACK_A;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_pd <= 1'b1;
                st     <= (st == ST_SUB) ? ST_ACK_S : ST_ACK_D;
              end
            end
          end
          ST_ACK_A: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw_q) begin
                sh      <= tx_byte;
                tx_stat <= ~id_sel;
                sda_pd  <= ~tx_byte[7];
                st      <= ST_TX;
              end else begin
                sda_pd <= 1'b0;
                st     <= ST_SUB;
              end
            end
          end
          ST_ACK_S: begin
            if (scl_fall) begin
              sda_pd <= 1'b0;
              ptr    <= sh;
              id_sel <= (sh == ID_SUBADDR);
              st     <= ST_DATA;
            end
          end
          ST_ACK_D: begin
            if (scl_fall) begin
              sda_pd <= 1'b0;
              if (ptr < DW'(NREG)) begin
                wr_en   <= 1'b1;
                wr_idx  <= ptr[IDXW-1:0];
                wr_data <= sh;
                ptr     <= (ptr == DW'(NREG - 1)) ? '0 : ptr + 1'b1;
              end
              st <= ST_DATA;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_pd <= 1'b0;
                st     <= ST_RACK;
              end else begin
                sda_pd <= ~sh[DW-2];
                sh     <= {sh[DW-2:0], 1'b0};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack    <= ~sda_s;
              por_clr <= tx_stat;
            end else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                sh      <= tx_byte;
                tx_stat <= ~id_sel;
                sda_pd  <= ~tx_byte[7];
                st      <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl_i2c_regbank.sv
module ctl_i2c_regbank
  import ctl_i2c_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDXW-1:0]          wr_idx,
  input  logic [DW-1:0]            wr_data,
  output logic [NREG-1:0][DW-1:0]  regs_q
);
  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          regs_q[g] <= reg_default(g);
        end else if (wr_en && wr_idx == IDXW'(g)) begin
          regs_q[g] <= wr_data & reg_mask(g);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ctl_i2c_regfile.sv
module ctl_i2c_regfile
  import ctl_i2c_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          adr_sel_i,
  input  logic [6:0]    stat_i,
  output logic          sda_pd_o,
  output logic [DW-1:0] sw_reg_o,
  output logic [DW-1:0] adj_reg_o,
  output logic [DW-1:0] port_reg_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic wr_en, por_clr, eng_active, por_q;
  logic [IDXW-1:0]         wr_idx;
  logic [DW-1:0]           wr_data;
  logic [NREG-1:0][DW-1:0] regs_q;

  ctl_i2c_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  ctl_i2c_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .adr_sel(adr_sel_i), .status_byte({por_q, stat_i}), .sda_pd(sda_pd_o),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .por_clr(por_clr),
    .active(eng_active)
  );

  ctl_i2c_regbank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_q(regs_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       por_q <= 1'b1;
    else if (por_clr) por_q <= 1'b0;
  end

  assign sw_reg_o   = regs_q[0];
  assign adj_reg_o  = regs_q[1];
  assign port_reg_o = regs_q[2];
endmodule

// File: rtl/ctl_i2c_regfile_chk.sv
module ctl_i2c_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pd_o,
  input logic [7:0] sw_reg_o,
  input logic [7:0] adj_reg_o,
  input logic [7:0] port_reg_o,
  input logic       scl_s,
  input logic       scl_fall,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       por_q,
  input logic       por_clr,
  input logic       eng_active
);
  p_port_top_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    port_reg_o[7:6] == 2'b00);

  p_commit_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({sw_reg_o, adj_reg_o, port_reg_o}) |-> $past(scl_fall, 2));

  p_sda_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pd_o) |-> (!$past(scl_s) || $past(start_ev) || $past(stop_ev)));

  p_por_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(por_q) |-> !por_q);

  p_por_clear_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_q) |-> $past(por_clr));

  p_pull_only_engaged_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pd_o |-> eng_active);
endmodule

bind ctl_i2c_regfile ctl_i2c_regfile_chk u_chk (.*);

// File: tb/ctl_i2c_regfile_tb_top.sv
module ctl_i2c_regfile_tb_top;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic adr_sel = 1'b1;
  logic [6:0] stat = 7'h15;
  logic sda_pd;
  logic [7:0] sw_r, adj_r, port_r;
  wire  sda_line = sda_m & ~sda_pd;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [7:0] m_reg [0:2];
  logic       m_por;
  logic       m_id;
  logic [7:0] dbuf [0:7];

  always #2.5 clk = ~clk;

  ctl_i2c_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .adr_sel_i(adr_sel), .stat_i(stat), .sda_pd_o(sda_pd),
    .sw_reg_o(sw_r), .adj_reg_o(adj_r), .port_reg_o(port_r)
  );

  function automatic logic [7:0] exp_mask(input int idx);
    return (idx == 2) ? 8'h3F : 8'hFF;
  endfunction

  function automatic logic [7:0] exp_read();
    return m_id ? 8'h80 : {m_por, stat};
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    wt(H/2); sda_m = 1'b1; wt(H/2); scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wt(H/2); sda_m = 1'b0; wt(H/2); scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    wt(H/2); sda_m = b; wt(H/2); scl_m = 1'b1; wt(H/2);
    s = sda_line; wt(H/2); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~give_ack, s);
    wt(H/2); sda_m = 1'b1;
  endtask

  task automatic model_write(input logic [7:0] sub, input int n);
    int idx;
    m_id = (sub == 8'hFE);
    if (sub < 8'd3) begin
      idx = int'(sub);
      for (int i = 0; i < n; i++) begin
        m_reg[idx] = dbuf[i] & exp_mask(idx);
        idx = (idx == 2) ? 0 : idx + 1;
      end
    end
  endtask

  task automatic wr_xfer(input logic [6:0] a7, input logic [7:0] sub, input int n,
                         input logic exp_ack, input string req);
    logic ack;
    bus_start();
    send_byte({a7, 1'b0}, ack);
    chk(ack == exp_ack, req, ack, exp_ack);
    if (exp_ack) begin
      send_byte(sub, ack);
      chk(ack, "R2 subaddress ack", ack, 1);
      for (int i = 0; i < n; i++) begin
        send_byte(dbuf[i], ack);
        chk(ack, "R2 data ack", ack, 1);
      end
      model_write(sub, n);
    end
    bus_stop();
  endtask

  task automatic rd_xfer(input logic [6:0] a7, input int n, input string req);
    logic ack;
    logic [7:0] b;
    logic [7:0] e;
    bus_start();
    send_byte({a7, 1'b1}, ack);
    chk(ack, "R1 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      e = exp_read();
      recv_byte(i < n - 1, b);
      chk(b == e, req, b, e);
      if (!m_id) m_por = 1'b0;
    end
    wt(H);
    chk(sda_pd == 1'b0, "R10 released after NACK", sda_pd, 0);
    bus_stop();
  endtask

  task automatic chk_regs(input string req);
    chk(sw_r == m_reg[0], req, sw_r, m_reg[0]);
    chk(adj_r == m_reg[1], req, adj_r, m_reg[1]);
    chk(port_r == m_reg[2], req, port_r, m_reg[2]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic s;
    void'($urandom(32'h5EED_0042));
    m_reg[0] = 8'hC0; m_reg[1] = 8'h06; m_reg[2] = 8'h3B;
    m_por = 1'b1; m_id = 1'b0;
    wt(5); rst_n = 1'b1; wt(5);

    // R5 reset state
    chk_regs("R5 reset defaults");
    chk(sda_pd == 1'b0, "R5 SDA released", sda_pd, 0);

    // R8 R9 plain status read, flag then cleared
    rd_xfer(7'h5B, 1, "R8 R9 first status read");
    rd_xfer(7'h5B, 2, "R9 flag stays cleared, R10 repeat");

    // R2 R3 single write and wrap
    dbuf[0] = 8'hA5;
    wr_xfer(7'h5B, 8'd0, 1, 1'b1, "R1 address ack");
    chk_regs("R2 single write");
    for (int i = 0; i < 5; i++) dbuf[i] = 8'h11 * (i + 3);
    wr_xfer(7'h5B, 8'd1, 5, 1'b1, "R1 address ack");
    chk_regs("R3 auto-increment wrap");
    dbuf[0] = 8'hFF;
    wr_xfer(7'h5B, 8'd2, 1, 1'b1, "R1 address ack");
    chk_regs("R6 port top bits forced 0");

    // R1 wrong address and select pin
    dbuf[0] = 8'h00;
    wr_xfer(7'h5A, 8'd0, 1, 1'b0, "R1 mismatch not acked");
    chk_regs("R1 mismatch leaves registers");
    adr_sel = 1'b0;
    dbuf[0] = 8'h3C;
    wr_xfer(7'h5A, 8'd0, 1, 1'b1, "R1 tied-low address acked");
    chk_regs("R1 tied-low address write");
    wr_xfer(7'h5B, 8'd0, 0, 1'b0, "R1 open address rejected when tied low");
    adr_sel = 1'b1;

    // R4 byte cut by STOP
    bus_start();
    send_byte(8'hB6, ack);
    send_byte(8'h01, ack);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    bus_stop();
    chk_regs("R4 partial byte ignored");

    // R11 out-of-range subaddress
    dbuf[0] = 8'h77; dbuf[1] = 8'h66;
    wr_xfer(7'h5B, 8'd7, 2, 1'b1, "R1 address ack");
    chk_regs("R11 out-of-range subaddress ignored");

    // R7 R10 identification path
    bus_start();
    send_byte(8'hB6, ack);
    send_byte(8'hFE, ack);
    chk(ack, "R7 id subaddress ack", ack, 1);
    m_id = 1'b1;
    rd_xfer(7'h5B, 3, "R7 R10 id byte repeated");
    rd_xfer(7'h5B, 1, "R7 id selection persists");
    dbuf[0] = 8'h42;
    wr_xfer(7'h5B, 8'd1, 1, 1'b1, "R1 address ack");
    stat = 7'h6A;
    rd_xfer(7'h5B, 2, "R7 R8 status after new subaddress");

    // R12 repeated start in the middle of a write
    bus_start();
    send_byte(8'hB6, ack);
    send_byte(8'h00, ack);
    send_byte(8'h9E, ack);
    m_reg[0] = 8'h9E;
    bus_start();
    send_byte(8'hB6, ack);
    chk(ack, "R12 address after repeated start", ack, 1);
    send_byte(8'h02, ack);
    send_byte(8'h2D, ack);
    m_reg[2] = 8'h2D;
    m_id = 1'b0;
    bus_stop();
    chk_regs("R12 repeated start write");

    // R3 R6 random writes with interleaved status reads
    for (int it = 0; it < 30; it++) begin
      int n;
      logic [7:0] sub;
      n = 1 + int'($urandom_range(3));
      sub = 8'($urandom_range(2));
      for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
      wr_xfer(7'h5B, sub, n, 1'b1, "R1 address ack");
      chk_regs("R3 R6 random write");
      if (it % 7 == 3) begin
        stat = 7'($urandom);
        rd_xfer(7'h5B, 2, "R8 random status read");
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule